// File: doc/BRIEF.md
# Counter Clock Source Selector

This block is the input front end of one counter channel. It turns whichever count source is selected into single-cycle up and down strobes in the system clock domain, which the counter behind it applies as increment and decrement. The sources are two external inputs (`ext_a`, `ext_b`), two internal free-running timebases, and the wrap pulses of a neighbouring channel for cascading.

A 3-bit `mode` input picks the source. Codes 0 and 1 count rising or falling edges of `ext_a`. Codes 2 and 3 count a slow tick (1 MHz by default) and a fast tick (one every 40 ns by default). Code 4 follows the neighbour's overflow and underflow pulses. Codes 5, 6 and 7 decode `ext_a`/`ext_b` as a quadrature pair at x1, x2 and x4 resolution.

The external inputs are asynchronous and pass through a two-flop synchronizer before edge detection. The cascade pulses come from logic on the same system clock and are taken as they are. Both strobes are registered.

Top module: `clk_src_sel`

## Requirements
- R1: While `rst_n` is low, `up_pulse` and `dn_pulse` are both 0.
- R2: With `mode`=0, each rising edge of `ext_a` yields exactly one `up_pulse` and no `dn_pulse`.
- R3: With `mode`=1, each falling edge of `ext_a` yields exactly one `up_pulse`, and rising edges yield none.
- R4: With `mode`=2, `up_pulse` fires exactly once per SYS_HZ/SLOW_HZ system cycles (50 at defaults), with no `dn_pulse`.
- R5: With `mode`=3, `up_pulse` fires exactly once per SYS_HZ/FAST_HZ system cycles (2 at defaults, i.e. every 40 ns).
- R6: With `mode`=4, a cycle with `casc_ovf` high and `casc_unf` low gives `up_pulse` on the following cycle. The reverse case gives `dn_pulse` on the following cycle. In any other mode both cascade inputs have no effect.
- R7: With `mode`=4, if `casc_ovf` and `casc_unf` are high in the same cycle, neither strobe fires.
- R8: With `mode`=5 (x1), only rising edges of `ext_a` count: up when `ext_b` is 0, down when `ext_b` is 1. One full quadrature cycle gives one strobe.
- R9: With `mode`=6 (x2), both edges of `ext_a` count. One full cycle gives two strobes.
- R10: With `mode`=7 (x4), every edge of `ext_a` or `ext_b` counts. One full cycle gives four strobes.
- R11: Quadrature direction: the sequence (A,B) 00,10,11,01 counts up and its reverse counts down. An A edge is up when A differs from B after the edge. A B edge is up when A equals B after the edge.
- R12: In quadrature modes, a sample in which `ext_a` and `ext_b` both changed produces no strobe.
- R13: `up_pulse` and `dn_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Count source select (0..7) |
| ext_a | input | 1 | External input A, asynchronous |
| ext_b | input | 1 | External input B, asynchronous |
| casc_ovf | input | 1 | Neighbour channel overflow pulse |
| casc_unf | input | 1 | Neighbour channel underflow pulse |
| up_pulse | output | 1 | Single-cycle increment strobe |
| dn_pulse | output | 1 | Single-cycle decrement strobe |

## Verification
Two events can land in one cycle in two places. The neighbour's overflow and underflow can arrive together in cascade mode. Both quadrature inputs can also toggle between two samples. The bench drives `casc_ovf` and `casc_unf` high on the same clock and requires both strobes to stay low. It also jumps the A/B pair from 00 to 11 and back in x4 mode and requires a count of zero in both directions. Separately, it checks every cycle of every scenario for an up and a down strobe at once.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    SRC_RISE_A = 3'd0,
    SRC_FALL_A = 3'd1,
    SRC_SLOW   = 3'd2,
    SRC_FAST   = 3'd3,
    SRC_CASC   = 3'd4,
    SRC_QX1    = 3'd5,
    SRC_QX2    = 3'd6,
    SRC_QX4    = 3'd7
  } src_mode_e;

endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/cs_tick_div.sv
module cs_tick_div #(
  parameter int SYS_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int RATIO = (SYS_HZ / TICK_HZ) < 1 ? 1 : (SYS_HZ / TICK_HZ);
  localparam int CW    = RATIO > 1 ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/cs_edge_quad.sv
module cs_edge_quad
  import clk_src_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a,
  input  logic      b,
  input  src_mode_e mode,
  output logic      rise_a,
  output logic      fall_a,
  output logic      q_up,
  output logic      q_dn
);

  logic a_q, b_q;
  logic da, db, only_a, only_b, a_dir_up, b_dir_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  always_comb begin
    da       = a ^ a_q;
    db       = b ^ b_q;
    rise_a   = a & ~a_q;
    fall_a   = ~a & a_q;
    only_a   = da & ~db;
    only_b   = db & ~da;
    a_dir_up = a ^ b;
    b_dir_up = ~(a ^ b);
    q_up     = 1'b0;
    q_dn     = 1'b0;
    unique case (mode)
      SRC_QX1: begin
        q_up = only_a & a & ~b;
        q_dn = only_a & a & b;
      end
      SRC_QX2: begin
        q_up = only_a & a_dir_up;
        q_dn = only_a & ~a_dir_up;
      end
      SRC_QX4: begin
        q_up = (only_a & a_dir_up) | (only_b & b_dir_up);
        q_dn = (only_a & ~a_dir_up) | (only_b & ~b_dir_up);
      end
      default: begin
        q_up = 1'b0;
        q_dn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_src_pkg::*;
#(
  parameter int SYS_HZ  = 50_000_000,
  parameter int SLOW_HZ = 1_000_000,
  parameter int FAST_HZ = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       ext_a,
  input  logic       ext_b,
  input  logic       casc_ovf,
  input  logic       casc_unf,
  output logic       up_pulse,
  output logic       dn_pulse
);

  src_mode_e  sel;
  logic [1:0] ab_s;
  logic       rise_a, fall_a, q_up, q_dn;
  logic       slow_tick, fast_tick;
  logic       up_d, dn_d, up_q, dn_q;

  assign sel = src_mode_e'(mode);

  cs_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_a, ext_b}),
    .q     (ab_s)
  );

  cs_edge_quad u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (ab_s[1]),
    .b      (ab_s[0]),
    .mode   (sel),
    .rise_a (rise_a),
    .fall_a (fall_a),
    .q_up   (q_up),
    .q_dn   (q_dn)
  );

  cs_tick_div #(.SYS_HZ(SYS_HZ), .TICK_HZ(SLOW_HZ)) u_slow (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slow_tick)
  );

  cs_tick_div #(.SYS_HZ(SYS_HZ), .TICK_HZ(FAST_HZ)) u_fast (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (fast_tick)
  );

  always_comb begin
    up_d = 1'b0;
    dn_d = 1'b0;
    unique case (sel)
      SRC_RISE_A: up_d = rise_a;
      SRC_FALL_A: up_d = fall_a;
      SRC_SLOW:   up_d = slow_tick;
      SRC_FAST:   up_d = fast_tick;
      SRC_CASC: begin
        up_d = casc_ovf & ~casc_unf;
        dn_d = casc_unf & ~casc_ovf;
      end
      default: begin
        up_d = q_up;
        dn_d = q_dn;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_pulse = up_q;
  assign dn_pulse = dn_q;

endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       casc_ovf,
  input logic       casc_unf,
  input logic       up_pulse,
  input logic       dn_pulse
);

  // R13
  p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_pulse && dn_pulse));

  // R2 R3 R4 R5: sources below code 4 never count down
  p_no_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) < 3'd4) |-> !dn_pulse);

  // R6: overflow alone in cascade mode increments next cycle
  p_casc_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd4 && $past(casc_ovf) && !$past(casc_unf)) |-> up_pulse);

  // R6: underflow alone in cascade mode decrements next cycle
  p_casc_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd4 && $past(casc_unf) && !$past(casc_ovf)) |-> dn_pulse);

  // R7
  p_casc_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd4 && $past(casc_ovf) && $past(casc_unf)) |-> (!up_pulse && !dn_pulse));

  // R1
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!up_pulse && !dn_pulse));

endmodule

bind clk_src_sel clk_src_sel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .casc_ovf (casc_ovf),
  .casc_unf (casc_unf),
  .up_pulse (up_pulse),
  .dn_pulse (dn_pulse)
);

// File: tb/tb_clk_src_sel.sv
`timescale 1ns/1ps
module tb_clk_src_sel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic       ext_a, ext_b, casc_ovf, casc_unf;
  logic       up_pulse, dn_pulse;

  int checks = 0;
  int errors = 0;
  int cu = 0;
  int cd = 0;
  int both = 0;

  always #10 clk = ~clk;

  clk_src_sel dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_a(ext_a), .ext_b(ext_b),
    .casc_ovf(casc_ovf), .casc_unf(casc_unf),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance n falling edges, accumulating strobes
  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      cu += int'(up_pulse);
      cd += int'(dn_pulse);
      if (up_pulse && dn_pulse) both++;
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    run(8);
    cu = 0;
    cd = 0;
  endtask

  task automatic ab(input logic a, input logic b);
    ext_a = a;
    ext_b = b;
    run(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    run(3);
    chk("R1 up", int'(up_pulse), 0);
    chk("R1 dn", int'(dn_pulse), 0);
    rst_n = 1'b1;
    run(3);
  endtask

  task automatic t_rise();
    set_mode(3'd0);
    for (int i = 0; i < 5; i++) begin ab(1, 0); ab(0, 0); end
    run(6);
    chk("R2 up count", cu, 5);
    chk("R2 dn count", cd, 0);
  endtask

  task automatic t_fall();
    set_mode(3'd1);
    ab(1, 0);
    chk("R3 rise ignored", cu, 0);
    for (int i = 0; i < 4; i++) begin ab(0, 0); ab(1, 0); end
    ab(0, 0);
    run(6);
    chk("R3 up count", cu, 5);
  endtask

  task automatic t_slow();
    set_mode(3'd2);
    run(200);
    chk("R4 slow ticks", cu, 4);
    chk("R4 dn count", cd, 0);
  endtask

  task automatic t_fast();
    set_mode(3'd3);
    run(20);
    chk("R5 fast ticks", cu, 10);
  endtask

  task automatic t_casc();
    set_mode(3'd4);
    casc_ovf = 1'b1;
    @(negedge clk);
    casc_ovf = 1'b0;
    chk("R6 ovf up", int'(up_pulse), 1);
    @(negedge clk);
    chk("R6 up single", int'(up_pulse), 0);
    casc_unf = 1'b1;
    @(negedge clk);
    casc_unf = 1'b0;
    chk("R6 unf dn", int'(dn_pulse), 1);
    @(negedge clk);
    cu = 0; cd = 0;
    casc_ovf = 1'b1; casc_unf = 1'b1;
    run(1);
    casc_ovf = 1'b0; casc_unf = 1'b0;
    run(3);
    chk("R7 both up", cu, 0);
    chk("R7 both dn", cd, 0);
    set_mode(3'd0);
    casc_ovf = 1'b1; run(2); casc_ovf = 1'b0;
    casc_unf = 1'b1; run(2); casc_unf = 1'b0;
    run(3);
    chk("R6 ignored outside mode 4", cu + cd, 0);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0); end
    run(6);
  endtask

  task automatic rev(input int n);
    for (int i = 0; i < n; i++) begin ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0); end
    run(6);
  endtask

  task automatic t_quad(input logic [2:0] m, input int per, input string req);
    set_mode(m);
    fwd(3);
    chk({req, " R11 fwd up"}, cu, 3 * per);
    chk({req, " R11 fwd dn"}, cd, 0);
    cu = 0; cd = 0;
    rev(3);
    chk({req, " R11 rev dn"}, cd, 3 * per);
    chk({req, " R11 rev up"}, cu, 0);
  endtask

  task automatic t_illegal();
    set_mode(3'd7);
    ab(1, 1);
    ab(0, 0);
    ab(1, 1);
    ab(0, 0);
    run(6);
    chk("R12 jump up", cu, 0);
    chk("R12 jump dn", cd, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; ext_a = 1'b0; ext_b = 1'b0;
    casc_ovf = 1'b0; casc_unf = 1'b0;
    t_reset();
    t_rise();
    t_fall();
    t_slow();
    t_fast();
    t_casc();
    t_quad(3'd5, 1, "R8 x1");
    t_quad(3'd6, 2, "R9 x2");
    t_quad(3'd7, 4, "R10 x4");
    t_illegal();
    chk("R13 never both", both, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule